// File: doc/BRIEF.md
# Triggered Timestamped Event Capture Logger

This block records the timing of level changes on one sampled input, together with the state of a group of companion inputs, over a bounded capture window. A free-running 24-bit timestamp counter advances on every clock. Software, or a host-side controller, arms the block. A rising edge on an external trigger input then opens the capture window. While the window is open, every change of the sampled input, in either direction, stores one 64-bit record in an on-chip buffer. The record holds the timestamp at the moment of the change and a snapshot of the companion inputs.

Capture closes when the programmed number of clock cycles has elapsed, or when the buffer runs out of space. The first of the two to occur closes it. The block then sits in a finished state and exposes the record count and a buffer-full indication. A transfer engine reads the stored records through a simple address/data port at its own pace, then clears the block back to idle. All pin-side inputs are asynchronous and pass through two-flop synchronizers before any use. The sampled input and the companion group share one synchronizer bank, so every record is taken from a single clock cycle.

Top module: `evtcap_logger`

## Requirements
- R1: After reset, the armed, capturing and finished flags are low, buffer_full is low, rec_count is 0 and rd_data is 0.
- R2: The timestamp counter increments by one every clock and wraps modulo 2^24. The difference between the timestamps of two records equals the number of clocks between the two pin changes that caused them.
- R3: A pulse on `arm` in idle sets the armed flag. A rising edge of the trigger while armed starts capture. A trigger edge while idle has no effect.
- R4: While capturing, each rising and each falling change of the sampled input stores exactly one record. Changes while idle or armed store nothing.
- R5: Record layout: bits [23:0] hold the timestamp, bits [47:24] hold the companion pins as seen in the same cycle as the change, and bits [63:48] are zero.
- R6: Records go to consecutive addresses starting at 0, in event order. rec_count equals the number stored and never exceeds the buffer depth.
- R7: Capture lasts exactly `win_len` clock cycles, with a value of 0 treated as 1. It then enters the finished state with buffer_full low.
- R8: The record that fills the last buffer slot ends capture at once and sets buffer_full. Later pin changes are not stored.
- R9: The finished state holds; trigger, arm and pin changes there have no effect. A `clear` pulse returns the block to idle with rec_count 0 and buffer_full low.
- R10: A read request with an address in idle or in the finished state returns that record on rd_data one clock later. In the armed or capturing state, a read request leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock (about 10 MHz in use) |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Single-cycle pulse that arms the block from idle |
| clear | input | 1 | Single-cycle pulse that returns the block from finished to idle |
| win_len | input | WIN_W | Capture window length in clocks, latched at the trigger |
| trig_async | input | 1 | Asynchronous external trigger; its rising edge starts capture |
| sample_async | input | 1 | Asynchronous input whose every level change stores a record |
| pins_async | input | PIN_W | Asynchronous companion pins snapshotted into each record |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Record address to read |
| rd_data | output | 64 | Record read, valid one clock after an accepted request |
| st_armed | output | 1 | Block is armed and waiting for the trigger |
| st_capt | output | 1 | Capture window is open |
| st_done | output | 1 | Capture has ended |
| buf_full | output | 1 | Capture ended because the buffer filled |
| rec_count | output | ADDR_W+1 | Number of records stored |

## Verification
The case that is hardest to reach from the ports is the buffer filling while the window is still open. This requires more pin changes than there are slots, packed inside a single window. The bench builds the block with an eight-entry buffer and a long window, then toggles the sampled input eleven times. It checks that the eighth record closes capture with the full flag set and that the last three changes leave no trace. The window length is swept over several small values, including zero, and the open time is counted cycle by cycle. Event spacing of one, two and five clocks exercises back-to-back edges.

// File: rtl/evtcap_pkg.sv
`timescale 1ns/1ps
// Shared types for the event capture logger.
package evtcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    localparam int REC_W = 64;
endpackage

// File: rtl/evtcap_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank.
// Assumes each bit is independent; callers that need a coherent group
// sample the group in one bank and use its outputs in the same cycle.
module evtcap_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/evtcap_tstamp.sv
`timescale 1ns/1ps
// Free-running timestamp counter.
// Starts at zero out of reset and wraps at 2^W.
module evtcap_tstamp #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] ts
);
    localparam logic [W-1:0] TS_ONE = W'(1);

    // Advance by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + TS_ONE;
    end
endmodule

// File: rtl/evtcap_ctrl.sv
`timescale 1ns/1ps
// Capture controller: arming, trigger detection, window timing,
// event detection and write addressing.
// Assumes trig_s and smp_s are already synchronized to clk.
module evtcap_ctrl
    import evtcap_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WIN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              clear,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              trig_s,
    input  logic              smp_s,
    output cap_state_e        state,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   count,
    output logic              full
);
    localparam int              DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W:0] CNT_ONE  = (ADDR_W+1)'(1);
    localparam logic [ADDR_W:0] CNT_LAST = (ADDR_W+1)'(DEPTH - 1);
    localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);

    logic             trig_prev;
    logic             smp_prev;
    logic [WIN_W-1:0] remain;
    logic             trig_rise;
    logic             smp_evt;

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_prev <= 1'b0;
            smp_prev  <= 1'b0;
        end else begin
            trig_prev <= trig_s;
            smp_prev  <= smp_s;
        end
    end

    // Decode trigger rise, sample-pin change and the write strobe.
    always_comb begin
        trig_rise = trig_s & ~trig_prev;
        smp_evt   = smp_s ^ smp_prev;
        we        = (state == ST_CAPT) && smp_evt;
        waddr     = count[ADDR_W-1:0];
    end

    // State sequencing, window countdown and record counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
            count  <= '0;
            full   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (arm) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (trig_rise) begin
                        state  <= ST_CAPT;
                        remain <= win_len;
                    end
                end
                ST_CAPT: begin
                    if (we) count <= count + CNT_ONE;
                    if (we && count == CNT_LAST) begin
                        full  <= 1'b1;
                        state <= ST_DONE;
                    end else if (remain <= WIN_ONE) begin
                        state <= ST_DONE;
                    end else begin
                        remain <= remain - WIN_ONE;
                    end
                end
                default: begin
                    if (clear) begin
                        state <= ST_IDLE;
                        count <= '0;
                        full  <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/evtcap_ram.sv
`timescale 1ns/1ps
// Simple dual-port record buffer with a registered read port.
// Assumes the caller never reads and writes the same slot in one cycle.
module evtcap_ram #(
    parameter int ADDR_W = 6,
    parameter int DW     = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] mem [DEPTH];

    // Store one record per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read; the output holds when no read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/evtcap_logger.sv
`timescale 1ns/1ps
// Triggered timestamped event capture logger (top).
// Synchronizes the pin-side inputs, builds records of timestamp and
// companion pins, and stores one per sample-pin change while capturing.
// Assumes TS_W + PIN_W <= 64; only that payload is stored, and the upper
// record bits are returned as zero.
module evtcap_logger
    import evtcap_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WIN_W  = 32,
    parameter int TS_W   = 24,
    parameter int PIN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              clear,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              trig_async,
    input  logic              sample_async,
    input  logic [PIN_W-1:0]  pins_async,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REC_W-1:0]  rd_data,
    output logic              st_armed,
    output logic              st_capt,
    output logic              st_done,
    output logic              buf_full,
    output logic [ADDR_W:0]   rec_count
);
    localparam int PAY_W  = TS_W + PIN_W;
    localparam int PAD_W  = REC_W - PAY_W;
    localparam int SYNC_W = PIN_W + 2;

    logic [SYNC_W-1:0] sync_q;
    logic              trig_s;
    logic              smp_s;
    logic [PIN_W-1:0]  pins_s;
    logic [TS_W-1:0]   ts_now;
    cap_state_e        state;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic              rd_ok;
    logic [PAY_W-1:0]  rd_pay;

    evtcap_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .d   ({trig_async, sample_async, pins_async}),
        .q   (sync_q)
    );

    evtcap_tstamp #(.W(TS_W)) u_ts (
        .clk (clk),
        .rst_n(rst_n),
        .ts  (ts_now)
    );

    evtcap_ctrl #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .clear  (clear),
        .win_len(win_len),
        .trig_s (trig_s),
        .smp_s  (smp_s),
        .state  (state),
        .we     (we),
        .waddr  (waddr),
        .count  (rec_count),
        .full   (buf_full)
    );

    evtcap_ram #(.ADDR_W(ADDR_W), .DW(PAY_W)) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .waddr(waddr),
        .wdata({pins_s, ts_now}),
        .re   (rd_ok),
        .raddr(rd_addr),
        .rdata(rd_pay)
    );

    // Split the synchronizer bank, gate reads, expose status, pad records.
    always_comb begin
        trig_s   = sync_q[SYNC_W-1];
        smp_s    = sync_q[SYNC_W-2];
        pins_s   = sync_q[PIN_W-1:0];
        rd_ok    = rd_en && (state == ST_IDLE || state == ST_DONE);
        st_armed = (state == ST_ARMED);
        st_capt  = (state == ST_CAPT);
        st_done  = (state == ST_DONE);
        rd_data  = {{PAD_W{1'b0}}, rd_pay};
    end
endmodule

// File: rtl/evtcap_checker.sv
`timescale 1ns/1ps
// Property checker for the event capture logger, bound to the top.
module evtcap_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              st_armed,
    input logic              st_capt,
    input logic              st_done,
    input logic              buf_full,
    input logic [ADDR_W:0]   rec_count,
    input logic [63:0]       rd_data
);
    localparam logic [ADDR_W:0] CNT_MAX = (ADDR_W+1)'(1 << ADDR_W);
    localparam logic [ADDR_W:0] CNT_ONE = (ADDR_W+1)'(1);

    // R3
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_armed, st_capt, st_done}));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_count <= CNT_MAX);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_capt |=> (rec_count == $past(rec_count) ||
                     rec_count == $past(rec_count) + CNT_ONE));

    // R4
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_capt && !(st_done && clear)) |=> $stable(rec_count));

    // R8
    full_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> st_done);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !clear) |=> st_done);

    // R9
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && clear) |=> (!st_done && !buf_full && rec_count == '0));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_armed || st_capt) |=> $stable(rd_data));
endmodule

bind evtcap_logger evtcap_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .st_armed (st_armed),
    .st_capt  (st_capt),
    .st_done  (st_done),
    .buf_full (buf_full),
    .rec_count(rec_count),
    .rd_data  (rd_data)
);

// File: tb/evtcap_logger_bench.sv
`timescale 1ns/1ps
// Self-checking bench for evtcap_logger with an 8-entry buffer.
module evtcap_logger_bench;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int WW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic          clear = 1'b0;
    logic [WW-1:0] win_len = '0;
    logic          trig = 1'b0;
    logic          smp = 1'b0;
    logic [23:0]   pins = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0]   rd_data;
    logic          st_armed, st_capt, st_done, buf_full;
    logic [AW:0]   rec_count;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     finished = 0;
    longint cyc = 0;
    int     captn = 0;
    longint ev_cyc [16];
    logic [23:0] ev_pin [16];

    always #2.5 clk = ~clk;

    evtcap_logger #(.ADDR_W(AW), .WIN_W(WW)) u_evtcap_logger (
        .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear), .win_len(win_len),
        .trig_async(trig), .sample_async(smp), .pins_async(pins),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .st_armed(st_armed), .st_capt(st_capt), .st_done(st_done),
        .buf_full(buf_full), .rec_count(rec_count)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (st_capt) captn <= captn + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [63:0] d);
        rd_en = 1'b1;
        rd_addr = AW'(a);
        tick(1);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        tick(1);
        arm = 1'b0;
        chk("R3 armed after arm", 64'(st_armed), 64'd1);
    endtask

    task automatic fire(input int wl);
        win_len = WW'(wl);
        captn = 0;
        trig = 1'b1;
        for (int k = 0; k < 20 && !st_capt; k++) tick(1);
        trig = 1'b0;
        chk("R3 capture started by trigger", 64'(st_capt), 64'd1);
    endtask

    task automatic wait_done(input int lim);
        for (int k = 0; k < lim && !st_done; k++) tick(1);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        tick(1);
        clear = 1'b0;
        chk("R9 clear leaves done", 64'(st_done), 64'd0);
        chk("R9 clear zeroes count", 64'(rec_count), 64'd0);
        chk("R9 clear drops full", 64'(buf_full), 64'd0);
    endtask

    function automatic logic [23:0] pat(input int run, input int i);
        return 24'h5A3C00 ^ 24'(run * 24'h111111) ^ 24'(i * 24'h010203);
    endfunction

    initial begin
        logic [63:0] d;
        logic [63:0] d0;
        int gaps [3] = '{1, 2, 5};

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 armed", 64'(st_armed), 64'd0);
        chk("R1 capt", 64'(st_capt), 64'd0);
        chk("R1 done", 64'(st_done), 64'd0);
        chk("R1 full", 64'(buf_full), 64'd0);
        chk("R1 count", 64'(rec_count), 64'd0);
        chk("R1 rd_data", rd_data, 64'd0);

        // R3: trigger while idle is ignored
        trig = 1'b1;
        tick(6);
        trig = 1'b0;
        chk("R3 idle trigger ignored (capt)", 64'(st_capt), 64'd0);
        chk("R3 idle trigger ignored (armed)", 64'(st_armed), 64'd0);
        tick(3);

        // R2 R4 R5 R6 R10: pattern sweep over event spacing and counts
        for (int run = 0; run < 3; run++) begin
            int nev = 3 + 2 * run;
            do_arm();
            // R4: changes while armed store nothing
            smp = ~smp; tick(3); smp = ~smp; tick(3);
            fire(300);
            if (run == 0) begin
                rd_en = 1'b1; rd_addr = '0;
                tick(3);
                rd_en = 1'b0;
                chk("R10 read in capture holds rd_data", rd_data, 64'd0);
            end
            for (int i = 0; i < nev; i++) begin
                pins = pat(run, i);
                ev_pin[i] = pins;
                ev_cyc[i] = cyc;
                smp = ~smp;
                tick(gaps[run]);
            end
            wait_done(400);
            chk("R7 done after window", 64'(st_done), 64'd1);
            chk("R7 window length", 64'(captn), 64'd300);
            chk("R7 full low", 64'(buf_full), 64'd0);
            chk("R6 record count", 64'(rec_count), 64'(nev));
            rd(0, d0);
            for (int i = 0; i < nev; i++) begin
                rd(i, d);
                chk("R5 pad bits zero", 64'(d[63:48]), 64'd0);
                chk("R5 pin snapshot", 64'(d[47:24]), 64'(ev_pin[i]));
                chk("R2 timestamp delta", 64'(24'(d[23:0] - d0[23:0])),
                    64'(24'(ev_cyc[i] - ev_cyc[0])));
            end
            do_clear();
            // R10: read allowed in idle returns stored record
            rd(1, d);
            chk("R10 idle read", 64'(d[47:24]), 64'(ev_pin[1]));
        end

        // R7: window length sweep, 0 behaves as 1
        for (int w = 0; w < 4; w++) begin
            int wl = (w == 0) ? 0 : (w == 1) ? 1 : (w == 2) ? 3 : 17;
            do_arm();
            fire(wl);
            wait_done(50);
            chk("R7 window sweep length", 64'(captn), 64'((wl == 0) ? 1 : wl));
            chk("R7 window sweep count", 64'(rec_count), 64'd0);
            do_clear();
        end

        // R8: buffer fills before the window ends
        do_arm();
        fire(3000);
        for (int i = 0; i < DEPTH + 3; i++) begin
            pins = pat(7, i);
            ev_pin[i] = pins;
            smp = ~smp;
            tick(4);
        end
        tick(4);
        chk("R8 done on full", 64'(st_done), 64'd1);
        chk("R8 full flag", 64'(buf_full), 64'd1);
        chk("R8 count at depth", 64'(rec_count), 64'(DEPTH));
        chk("R8 ended early", 64'(captn < 3000), 64'd1);
        rd(DEPTH - 1, d);
        chk("R8 last slot record", 64'(d[47:24]), 64'(ev_pin[DEPTH-1]));
        rd(0, d);
        chk("R6 first slot record", 64'(d[47:24]), 64'(ev_pin[0]));

        // R9: done ignores trigger, arm and pin changes
        trig = 1'b1; arm = 1'b1; smp = ~smp;
        tick(1);
        arm = 1'b0;
        tick(6);
        trig = 1'b0;
        chk("R9 done holds", 64'(st_done), 64'd1);
        chk("R9 no arm in done", 64'(st_armed), 64'd0);
        chk("R9 count unchanged", 64'(rec_count), 64'(DEPTH));
        do_clear();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule